// File: doc/BRIEF.md
# VLAN-aware frame length checker

This block watches the byte stream of received Ethernet frames and reports two facts about each frame when the frame ends. The first is whether the frame carries a VLAN tag. The second is whether the frame is longer than the largest size allowed for its kind.

A frame is a run of accepted bytes. A start marker sits on the first byte and an end marker sits on the last byte. The block counts the bytes and compares the two bytes at the type/length position with a tag identifier held in a small register. It then picks one of two length limits, depending on whether the tag was found.

The tag identifier register is 32 bits wide, but only its low half holds state. It resets to zero, so software must program it (normally to 0x8100) before tagged frames can be recognised. The block computes no CRC, filters no addresses and removes no tags.

Top module: `vlan_len_checker`

## Requirements
- R1: After reset, `reg_rdata` reads 0 and `res_valid`, `res_vlan` and `res_too_long` are all 0.
- R2: A write (`reg_wr`=1) stores `reg_wdata[15:0]` as the tag identifier. `reg_rdata` returns `{16'h0, tag}` from the cycle after the write, and `reg_wdata[31:16]` has no effect.
- R3: A byte is accepted when `in_valid`=1 and either `in_sof`=1 or a frame is open. A byte with `in_sof`=1 is byte 1 of a new frame. A byte with `in_eof`=1 closes the frame, and the closing byte counts toward the length. Cycles with `in_valid`=0 add nothing to the length. Bytes outside a frame that carry no start marker are ignored, even if they carry `in_eof`.
- R4: `res_valid` is high for exactly the one cycle after the clock edge that accepts the closing byte. `res_vlan` and `res_too_long` are 0 whenever `res_valid` is 0.
- R5: A frame is marked VLAN (`res_vlan`=1) when `{byte 13, byte 14}` equals the tag identifier, with byte 13 as the most significant byte. Byte 1 is the start byte. The register value used is the one held when byte 14 is accepted.
- R6: A frame shorter than 14 bytes is never marked VLAN.
- R7: For an untagged frame, `res_too_long` is 1 exactly when the length exceeds `MAX_UNTAGGED` (1518).
- R8: For a VLAN frame, `res_too_long` is 1 exactly when the length exceeds `MAX_TAGGED` (1522).
- R9: The byte counter saturates at 2^`CNT_W`-1 (4095) instead of wrapping, so a frame of any longer length is still flagged too long.
- R10: A start marker inside an open frame abandons that frame without a result and starts a new one, with the length and the tag state cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the tag identifier register |
| reg_wdata | input | 32 | Write data; only bits 15:0 are stored |
| reg_rdata | output | 32 | Register read value, upper half always zero |
| in_valid | input | 1 | Byte on `in_data` is present this cycle |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| res_valid | output | 1 | One-cycle pulse after a frame closes |
| res_vlan | output | 1 | Frame carried the programmed tag |
| res_too_long | output | 1 | Frame exceeded its length limit |

## Verification
The bench builds the block with its default parameters: limits of 1518 and 1522, a 12-bit counter, and the tag at byte 13. With these values, frames at one byte below, at, and one byte above each limit are short enough to send directly. The 4095 saturation point can also be passed with frames of a few thousand bytes. Because the counter width stays at its default, the saturation case exercises the real boundary rather than a shrunken one. It shows that a wrap cannot make an oversized frame look legal.

// File: rtl/vlan_len_checker.sv
module vlan_len_checker #(
  parameter int MAX_UNTAGGED = 1518,
  parameter int MAX_TAGGED   = 1522,
  parameter int CNT_W        = 12,
  parameter int TAG_BYTE     = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_eof,
  output logic        res_valid,
  output logic        res_vlan,
  output logic        res_too_long
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LIM_U   = CNT_W'(MAX_UNTAGGED);
  localparam logic [CNT_W-1:0] LIM_T   = CNT_W'(MAX_TAGGED);
  localparam logic [CNT_W-1:0] IDX_HI  = CNT_W'(TAG_BYTE);
  localparam logic [CNT_W-1:0] IDX_LO  = CNT_W'(TAG_BYTE + 1);

  logic [15:0]      tag_q;
  logic [7:0]       hi_q;
  logic [CNT_W-1:0] cnt_q;
  logic             open_q;
  logic             vlan_q;

  logic             unused_wr_hi;
  assign unused_wr_hi = ^reg_wdata[31:16];

  logic             acc;
  logic [CNT_W-1:0] cnt_nx;
  logic             vlan_nx;
  logic             long_nx;

  assign acc     = in_valid & (in_sof | open_q);
  assign cnt_nx  = in_sof ? CNT_W'(1) : ((cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1);
  assign vlan_nx = (~in_sof & vlan_q) | ((cnt_nx == IDX_LO) && ({hi_q, in_data} == tag_q));
  assign long_nx = cnt_nx > (vlan_nx ? LIM_T : LIM_U);

  assign reg_rdata = {16'h0000, tag_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag_q <= '0;
    else if (reg_wr) tag_q <= reg_wdata[15:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
      hi_q   <= '0;
      vlan_q <= 1'b0;
    end else if (acc) begin
      open_q <= ~in_eof;
      cnt_q  <= cnt_nx;
      vlan_q <= vlan_nx;
      if (cnt_nx == IDX_HI) hi_q <= in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_vlan     <= 1'b0;
      res_too_long <= 1'b0;
    end else begin
      res_valid    <= acc & in_eof;
      res_vlan     <= acc & in_eof & vlan_nx;
      res_too_long <= acc & in_eof & long_nx;
    end
  end

  // R4: a result only follows an accepted closing byte, and flags only ride on it
  p_pulse_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid && in_eof));
  p_flags_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vlan || res_too_long) |-> res_valid);
  // R2: the register only changes on a write
  p_tag_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(reg_rdata));
  p_tag_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_rdata[15:0] == $past(reg_wdata[15:0]));
  // R6: short frames are never tagged
  p_short_untagged_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(cnt_nx < IDX_LO)) |-> !res_vlan);
  // R9: the counter holds at its ceiling
  p_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_sof && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
  // R7: an untagged frame within the limit is never flagged
  p_untag_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_vlan && $past(cnt_nx <= LIM_U)) |-> !res_too_long);

endmodule

// File: tb/vlan_len_checker_bench.sv
module vlan_len_checker_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_sof = 1'b0;
  logic        in_eof = 1'b0;
  logic        res_valid, res_vlan, res_too_long;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlan_len_checker u_vlan_len_checker (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .res_valid(res_valid),
    .res_vlan(res_vlan), .res_too_long(res_too_long));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_tag(logic [31:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  // Sends a frame; gap>0 inserts an idle cycle after every gap bytes.
  task automatic send(int len, logic [7:0] b13, logic [7:0] b14, int gap, bit close);
    for (int i = 1; i <= len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = (i == 1);
      in_eof   = close && (i == len);
      in_data  = (i == 13) ? b13 : (i == 14) ? b14 : 8'(i * 7);
      if (gap > 0 && i % gap == 0 && i != len) begin
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic frame(string req, int len, logic [7:0] b13, logic [7:0] b14,
                       int gap, bit exp_vlan, bit exp_long);
    send(len, b13, b14, gap, 1'b1);
    check({req, " valid"}, 32'(res_valid), 32'd1);
    check({req, " vlan"}, 32'(res_vlan), 32'(exp_vlan));
    check({req, " too_long"}, 32'(res_too_long), 32'(exp_long));
    @(negedge clk);
    check({req, " pulse end (R4)"}, 32'(res_valid), 32'd0);
  endtask

  task automatic t_reset;
    check("R1 rdata", reg_rdata, 32'd0);
    check("R1 valid", 32'(res_valid), 32'd0);
    check("R1 flags", 32'({res_vlan, res_too_long}), 32'd0);
  endtask

  task automatic t_zero_tag;
    frame("R5 reset tag 0", 64, 8'h00, 8'h00, 0, 1'b1, 1'b0);
  endtask

  task automatic t_register;
    write_tag(32'hDEAD_8100);
    check("R2 read", reg_rdata, 32'h0000_8100);
  endtask

  task automatic t_detect;
    frame("R5 untagged", 64, 8'h08, 8'h00, 0, 1'b0, 1'b0);
    frame("R5 tagged", 64, 8'h81, 8'h00, 0, 1'b1, 1'b0);
    frame("R5 byte order", 64, 8'h00, 8'h81, 0, 1'b0, 1'b0);
    frame("R5 exactly 14", 14, 8'h81, 8'h00, 0, 1'b1, 1'b0);
    frame("R6 13 bytes", 13, 8'h81, 8'h00, 0, 1'b0, 1'b0);
    frame("R6 1 byte", 1, 8'h81, 8'h00, 0, 1'b0, 1'b0);
  endtask

  task automatic t_limits;
    frame("R7 untagged 1518", 1518, 8'h08, 8'h00, 0, 1'b0, 1'b0);
    frame("R7 untagged 1519", 1519, 8'h08, 8'h00, 0, 1'b0, 1'b1);
    frame("R7 untagged 1522", 1522, 8'h08, 8'h00, 0, 1'b0, 1'b1);
    frame("R8 tagged 1522", 1522, 8'h81, 8'h00, 0, 1'b1, 1'b0);
    frame("R8 tagged 1523", 1523, 8'h81, 8'h00, 0, 1'b1, 1'b1);
  endtask

  task automatic t_framing;
    @(negedge clk);
    in_valid = 1'b1; in_eof = 1'b1; in_data = 8'h55;
    @(negedge clk);
    in_valid = 1'b0; in_eof = 1'b0;
    check("R3 stray byte ignored", 32'(res_valid), 32'd0);
    frame("R3 gaps 1518", 1518, 8'h08, 8'h00, 7, 1'b0, 1'b0);
    frame("R3 gaps tagged 1522", 1522, 8'h81, 8'h00, 5, 1'b1, 1'b0);
  endtask

  task automatic t_saturate;
    frame("R9 untagged 5000", 5000, 8'h08, 8'h00, 0, 1'b0, 1'b1);
    frame("R9 tagged 4500", 4500, 8'h81, 8'h00, 0, 1'b1, 1'b1);
  endtask

  task automatic t_restart;
    send(2000, 8'h81, 8'h00, 0, 1'b0);
    check("R10 no result for abandoned frame", 32'(res_valid), 32'd0);
    frame("R10 restart", 64, 8'h08, 8'h00, 0, 1'b0, 1'b0);
  endtask

  task automatic t_new_tag;
    write_tag(32'hFFFF_88A8);
    check("R2 read new", reg_rdata, 32'h0000_88A8);
    frame("R5 new tag hit", 1520, 8'h88, 8'hA8, 0, 1'b1, 1'b0);
    frame("R5 old tag miss", 1520, 8'h81, 8'h00, 0, 1'b0, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 1ns);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_tag();
    t_register();
    t_detect();
    t_limits();
    t_framing();
    t_saturate();
    t_restart();
    t_new_tag();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule